// File: doc/BRIEF.md
# NaN propagation unit

This block sits ahead of a two-operand IEEE 754 arithmetic datapath and settles the result whenever either operand is a NaN. Each operand arrives with a type code computed upstream. The block picks the NaN that wins a fixed priority. It turns a signalling NaN into a quiet one. When the control register asks for it, it puts the format's default NaN in place of the propagated value. It reports through a single flag whether the datapath's own result must be overridden.

The block also owns a 32-bit control and status register. The register holds trap-enable bits and sticky cumulative flags for five exceptions. Invalid Operation is raised here when a signalling NaN is consumed. The other four exceptions (overflow, underflow, inexact, input-denormal) are reported by the downstream datapath on a side input. An exception whose enable bit is set raises a trap request in place of setting its flag. The NaN flag, the result value and the trap request are all combinational, so they are valid in the same cycle as the operands. The register updates on the next clock edge.

Top module: `nan_propagate`

## Requirements
- R1: `fmt_dbl`=0 selects 32-bit operands held in bits [31:0], with the quiet bit at 22; bits [63:32] of the result are then 0. `fmt_dbl`=1 selects 64-bit operands with the quiet bit at 51.
- R2: Type codes are 0 zero, 1 normal, 2 infinity, 3 quiet NaN and 4 signalling NaN. The winning operand is chosen in this order: operand A signalling, then operand B signalling, then operand A quiet, then operand B quiet.
- R3: When neither operand is a NaN, `nan_hit` is 0 and `result` is all zeros.
- R4: A winning signalling NaN is passed through with its quiet bit forced to 1 and every other bit unchanged. A winning quiet NaN is passed through unchanged.
- R5: With control bit 25 (default-NaN mode) set, every NaN result is replaced by the default NaN: 32'h7FC00000 for 32-bit operands and 64'h7FF8000000000000 for 64-bit operands.
- R6: When `op_valid` is 1 and either operand is a signalling NaN, an Invalid Operation is raised. Its enable bit is 8 and its cumulative bit is 0.
- R7: `exc_raise` bits [0..3] report overflow, underflow, inexact and input-denormal, and they act only while `op_valid` is 1. Their enable bits are 10, 11, 12 and 15, and their cumulative bits are 2, 3, 4 and 7.
- R8: A raised exception whose enable bit is set drives `trap_req` high in that cycle and leaves its cumulative bit unchanged. A raised exception whose enable bit is clear sets its cumulative bit at the next edge.
- R9: Cumulative bits are sticky. New flags are ORed in, and the bits clear only through a register write or reset.
- R10: When a register write and an exception come in the same cycle, the written value is stored and the new flag is then ORed into it.
- R11: Quiet NaN operands raise no exception and leave the register unchanged.
- R12: Reset clears the whole control register to zero.
- R13: `nan_hit`, `result` and `trap_req` follow the inputs in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_dbl | input | 1 | 0 selects 32-bit operands, 1 selects 64-bit operands |
| op_valid | input | 1 | An operation is presented this cycle, so exceptions count |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| kind_a | input | 3 | Type code of operand A |
| kind_b | input | 3 | Type code of operand B |
| exc_raise | input | 4 | Datapath exceptions: overflow, underflow, inexact, input-denormal |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 32 | Write data for the control register |
| ctl_q | output | 32 | Current control register contents |
| nan_hit | output | 1 | A NaN operand decided the result |
| result | output | 64 | NaN result, valid when `nan_hit` is 1 |
| trap_req | output | 1 | An enabled exception was raised this cycle |

## Verification
The bench builds the block with its default parameters: a 32-bit control register and five exceptions. This places every fixed enable and cumulative position in range. Because the format is chosen on a port rather than by a parameter, one build drives both widths. The stimulus covers quiet-bit placement at 22 and 51, stray upper bits on 32-bit operands, and both default NaN patterns. One elaboration also reaches the same-cycle write-and-flag merge, and a trap that takes the place of a flag.

// File: rtl/nanp_pkg.sv
package nanp_pkg;

    localparam int OPW      = 64;
    localparam int SP_W     = 32;
    localparam int SP_QBIT  = 22;
    localparam int DP_QBIT  = 51;
    localparam int CTL_W    = 32;
    localparam int NUM_EXC  = 5;
    localparam int DN_BIT   = 25;

    typedef enum logic [2:0] {
        K_ZERO = 3'd0,
        K_NORM = 3'd1,
        K_INF  = 3'd2,
        K_QNAN = 3'd3,
        K_SNAN = 3'd4
    } kind_e;

    // exception index: 0 invalid, 1 overflow, 2 underflow, 3 inexact, 4 input-denormal
    function automatic int en_pos(input int idx);
        case (idx)
            0:       return 8;
            1:       return 10;
            2:       return 11;
            3:       return 12;
            default: return 15;
        endcase
    endfunction

    function automatic int cum_pos(input int idx);
        case (idx)
            0:       return 0;
            1:       return 2;
            2:       return 3;
            3:       return 4;
            default: return 7;
        endcase
    endfunction

    function automatic logic [OPW-1:0] default_nan(input logic dbl);
        if (dbl) return 64'h7FF8_0000_0000_0000;
        return {{(OPW-SP_W){1'b0}}, 32'h7FC0_0000};
    endfunction

    function automatic logic [OPW-1:0] quiet_mask(input logic dbl);
        logic [OPW-1:0] m;
        m = '0;
        if (dbl) m[DP_QBIT] = 1'b1;
        else     m[SP_QBIT] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/nanp_select.sv
module nanp_select
    import nanp_pkg::*;
#(
    parameter int W = OPW
) (
    input  logic         dbl,
    input  logic         dn_mode,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [2:0]   kind_a,
    input  logic [2:0]   kind_b,
    output logic         hit,
    output logic         invalid,
    output logic [W-1:0] res
);
    localparam int NOPS = 2;

    logic [NOPS-1:0] is_snan;
    logic [NOPS-1:0] is_qnan;
    logic [W-1:0]    narrow [NOPS];
    logic [2:0]      kinds  [NOPS];
    logic [W-1:0]    raw    [NOPS];

    assign kinds[0] = kind_a;
    assign kinds[1] = kind_b;
    assign raw[0]   = op_a;
    assign raw[1]   = op_b;

    for (genvar g = 0; g < NOPS; g++) begin : g_opnd
        assign is_snan[g] = (kind_e'(kinds[g]) == K_SNAN);
        assign is_qnan[g] = (kind_e'(kinds[g]) == K_QNAN);
        assign narrow[g]  = dbl ? raw[g] : {{(W-SP_W){1'b0}}, raw[g][SP_W-1:0]};
    end

    logic [W-1:0] pick_d;
    logic         sig_d;
    logic         hit_d;

    always_comb begin
        hit_d  = 1'b1;
        sig_d  = 1'b0;
        pick_d = '0;
        if (is_snan[0]) begin
            pick_d = narrow[0];
            sig_d  = 1'b1;
        end else if (is_snan[1]) begin
            pick_d = narrow[1];
            sig_d  = 1'b1;
        end else if (is_qnan[0]) begin
            pick_d = narrow[0];
        end else if (is_qnan[1]) begin
            pick_d = narrow[1];
        end else begin
            hit_d  = 1'b0;
        end
        if (sig_d) pick_d = pick_d | quiet_mask(dbl);
        if (hit_d && dn_mode) pick_d = default_nan(dbl);
    end

    assign hit     = hit_d;
    assign invalid = |is_snan;
    assign res     = pick_d;

endmodule

// File: rtl/nanp_ctl.sv
module nanp_ctl
    import nanp_pkg::*;
#(
    parameter int CW = CTL_W,
    parameter int NE = NUM_EXC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NE-1:0] exc,
    input  logic          we,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] ctl_q,
    output logic          trap,
    output logic          dn_mode
);
    typedef struct packed {
        logic [CW-1:0] ctl_val;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic [NE-1:0] to_trap;
    logic [NE-1:0] to_flag;
    logic [CW-1:0] flag_mask;
    logic [CW-1:0] cum_mask;

    for (genvar g = 0; g < NE; g++) begin : g_exc
        assign to_trap[g] = exc[g] &  st_q.ctl_val[en_pos(g)];
        assign to_flag[g] = exc[g] & ~st_q.ctl_val[en_pos(g)];
    end

    always_comb begin
        flag_mask = '0;
        cum_mask  = '0;
        for (int i = 0; i < NE; i++) begin
            cum_mask[cum_pos(i)] = 1'b1;
            if (to_flag[i]) flag_mask[cum_pos(i)] = 1'b1;
        end
        st_d.ctl_val = (we ? wdata : st_q.ctl_val) | flag_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl_q   = st_q.ctl_val;
    assign trap    = |to_trap;
    assign dn_mode = st_q.ctl_val[DN_BIT];

    // R9: without a write, no cumulative bit ever falls
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ((ctl_q & cum_mask) & $past(ctl_q & cum_mask)) == $past(ctl_q & cum_mask));

    // R8: an enabled overflow leaves its cumulative bit untouched
    a_r8_trap_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (exc[1] && ctl_q[10] && !we) |=> ctl_q[2] == $past(ctl_q[2]));

    // R10: a written value plus a disabled overflow lands as the value with bit 2 set
    a_r10_write_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (we && exc[1] && !ctl_q[10]) |=> ctl_q == ($past(wdata) | 32'h4));

endmodule

// File: rtl/nan_propagate.sv
module nan_propagate
    import nanp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fmt_dbl,
    input  logic        op_valid,
    input  logic [63:0] op_a,
    input  logic [63:0] op_b,
    input  logic [2:0]  kind_a,
    input  logic [2:0]  kind_b,
    input  logic [3:0]  exc_raise,
    input  logic        ctl_we,
    input  logic [31:0] ctl_wdata,
    output logic [31:0] ctl_q,
    output logic        nan_hit,
    output logic [63:0] result,
    output logic        trap_req
);
    logic               dn_mode;
    logic               invalid;
    logic [NUM_EXC-1:0] exc_vec;

    nanp_select #(.W(OPW)) u_sel (
        .dbl     (fmt_dbl),
        .dn_mode (dn_mode),
        .op_a    (op_a),
        .op_b    (op_b),
        .kind_a  (kind_a),
        .kind_b  (kind_b),
        .hit     (nan_hit),
        .invalid (invalid),
        .res     (result)
    );

    assign exc_vec = {exc_raise, invalid} & {NUM_EXC{op_valid}};

    nanp_ctl #(.CW(CTL_W), .NE(NUM_EXC)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .exc     (exc_vec),
        .we      (ctl_we),
        .wdata   (ctl_wdata),
        .ctl_q   (ctl_q),
        .trap    (trap_req),
        .dn_mode (dn_mode)
    );

    // R2: a signalling operand A always produces a hit
    a_r2_snan_a_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_a == 3'd4) |-> nan_hit);

    // R4: a signalling winner comes out quiet unless default mode replaces it
    a_r4_quieted: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind_a == 3'd4 || kind_b == 3'd4) && !ctl_q[DN_BIT])
        |-> result[fmt_dbl ? DP_QBIT : SP_QBIT]);

    // R5: default mode yields the default NaN of the format
    a_r5_default: assert property (@(posedge clk) disable iff (!rst_n)
        (nan_hit && ctl_q[DN_BIT]) |-> result == (fmt_dbl ? 64'h7FF8_0000_0000_0000 : 64'h7FC0_0000));

    // R3: no NaN operand means no hit and a zero result
    a_r3_no_nan: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_a < 3'd3 && kind_b < 3'd3) |-> (!nan_hit && result == '0));

    // R11: quiet NaNs alone change nothing in the register
    a_r11_qnan_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && kind_a != 3'd4 && kind_b != 3'd4 && exc_raise == '0 && !ctl_we)
        |=> ctl_q == $past(ctl_q));

endmodule

// File: tb/nan_propagate_test.sv
module nan_propagate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fmt_dbl = 1'b0;
    logic        op_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [2:0]  kind_a = 3'd0;
    logic [2:0]  kind_b = 3'd0;
    logic [3:0]  exc_raise = '0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_q;
    logic        nan_hit;
    logic [63:0] result;
    logic        trap_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    nan_propagate uut (
        .clk(clk), .rst_n(rst_n), .fmt_dbl(fmt_dbl), .op_valid(op_valid),
        .op_a(op_a), .op_b(op_b), .kind_a(kind_a), .kind_b(kind_b),
        .exc_raise(exc_raise), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_q(ctl_q), .nan_hit(nan_hit), .result(result), .trap_req(trap_req)
    );

    typedef struct packed {
        logic        dbl;
        logic [2:0]  ka;
        logic [2:0]  kb;
        logic [63:0] a;
        logic [63:0] b;
        logic        hit;
        logic [63:0] res;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd1, 3'd1, 64'h3F80_0000, 64'h4000_0000, 1'b0, 64'h0},
        '{1'b0, 3'd4, 3'd3, 64'h7F80_0001, 64'h7FC0_0005, 1'b1, 64'h7FC0_0001},
        '{1'b0, 3'd3, 3'd4, 64'hFFC0_0123, 64'h7FA0_0000, 1'b1, 64'h7FE0_0000},
        '{1'b0, 3'd3, 3'd3, 64'hFFC0_0123, 64'h7FC0_0777, 1'b1, 64'hFFC0_0123},
        '{1'b0, 3'd1, 3'd3, 64'h3F80_0000, 64'h7FD0_0000, 1'b1, 64'h7FD0_0000},
        '{1'b1, 3'd4, 3'd1, 64'hFFF0_0000_0000_0001, 64'h3FF0_0000_0000_0000, 1'b1, 64'hFFF8_0000_0000_0001},
        '{1'b1, 3'd2, 3'd4, 64'h7FF0_0000_0000_0000, 64'h7FF4_0000_0000_0000, 1'b1, 64'h7FFC_0000_0000_0000},
        '{1'b1, 3'd4, 3'd4, 64'h7FF0_0000_0000_00AA, 64'hFFF0_0000_0000_0001, 1'b1, 64'h7FF8_0000_0000_00AA},
        '{1'b1, 3'd0, 3'd2, 64'h0, 64'h7FF0_0000_0000_0000, 1'b0, 64'h0},
        '{1'b0, 3'd4, 3'd0, 64'hDEAD_BEEF_7F80_0010, 64'h0, 1'b1, 64'h7FC0_0010}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_op(input logic dbl, input logic [2:0] ka, input logic [2:0] kb,
                          input logic [63:0] a, input logic [63:0] b, input logic v,
                          input logic [3:0] ex);
        @(negedge clk);
        fmt_dbl = dbl; kind_a = ka; kind_b = kb; op_a = a; op_b = b;
        op_valid = v; exc_raise = ex;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        op_valid = 1'b0; exc_raise = '0; kind_a = 3'd1; kind_b = 3'd1; ctl_we = 1'b0;
        #1;
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        op_valid = 1'b0; exc_raise = '0; ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 reset clears register", 64'(ctl_q), 64'h0);
        rst_n = 1'b1;
        idle();
        chk("R12 register zero after reset release", 64'(ctl_q), 64'h0);

        // R1 R2 R3 R4 R13: table walk, combinational sampling before next edge
        for (int i = 0; i < NV; i++) begin
            put_op(VECS[i].dbl, VECS[i].ka, VECS[i].kb, VECS[i].a, VECS[i].b, 1'b0, 4'h0);
            chk("R2 R13 nan_hit", 64'(nan_hit), 64'(VECS[i].hit));
            chk("R1 R4 result", result, VECS[i].res);
        end
        idle();
        chk("R11 no op_valid leaves register", 64'(ctl_q), 64'h0);

        // R6: invalid flag
        put_op(1'b0, 3'd4, 3'd1, 64'h7F80_0001, 64'h0, 1'b1, 4'h0);
        chk("R6 no trap when disabled", 64'(trap_req), 64'h0);
        idle();
        chk("R6 invalid cumulative bit 0", 64'(ctl_q), 64'h1);

        // R9: sticky through a clean operation
        put_op(1'b0, 3'd1, 3'd1, 64'h0, 64'h0, 1'b1, 4'h0);
        idle();
        chk("R9 flag stays set", 64'(ctl_q), 64'h1);
        wr(32'h0);
        chk("R9 write clears flag", 64'(ctl_q), 64'h0);

        // R11: quiet NaNs raise nothing
        put_op(1'b1, 3'd3, 3'd3, 64'h7FF8_0000_0000_0001, 64'h7FF8_0000_0000_0002, 1'b1, 4'h0);
        chk("R11 no trap on quiet NaN", 64'(trap_req), 64'h0);
        idle();
        chk("R11 register unchanged", 64'(ctl_q), 64'h0);

        // R8: enabled invalid traps and sets no flag
        wr(32'h0000_0100);
        put_op(1'b0, 3'd3, 3'd4, 64'h7FC0_0000, 64'h7F80_0002, 1'b1, 4'h0);
        chk("R8 trap on enabled invalid", 64'(trap_req), 64'h1);
        idle();
        chk("R8 no cumulative on trap", 64'(ctl_q), 64'h100);

        // R7: all datapath exceptions with enables clear
        wr(32'h0);
        put_op(1'b0, 3'd1, 3'd1, 64'h0, 64'h0, 1'b1, 4'hF);
        chk("R7 no trap when disabled", 64'(trap_req), 64'h0);
        idle();
        chk("R7 cumulative bits 2,3,4,7", 64'(ctl_q), 64'h9C);

        // R7: ignored without op_valid
        wr(32'h0);
        put_op(1'b0, 3'd1, 3'd1, 64'h0, 64'h0, 1'b0, 4'hF);
        idle();
        chk("R7 exceptions ignored without op_valid", 64'(ctl_q), 64'h0);

        // R8: underflow enabled at bit 11
        wr(32'h0000_0800);
        put_op(1'b0, 3'd1, 3'd1, 64'h0, 64'h0, 1'b1, 4'b0010);
        chk("R8 underflow trap", 64'(trap_req), 64'h1);
        idle();
        chk("R8 underflow flag not set", 64'(ctl_q), 64'h800);
        put_op(1'b0, 3'd1, 3'd1, 64'h0, 64'h0, 1'b1, 4'b0001);
        chk("R8 overflow not enabled no trap", 64'(trap_req), 64'h0);
        idle();
        chk("R7 overflow flag bit 2", 64'(ctl_q), 64'h804);

        // R10: write and inexact in the same cycle
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = 32'h0000_0020; op_valid = 1'b1; exc_raise = 4'b0100;
        kind_a = 3'd1; kind_b = 3'd1;
        idle();
        chk("R10 write then OR flag", 64'(ctl_q), 64'h30);

        // R5: default NaN mode
        wr(32'h0200_0000);
        put_op(1'b0, 3'd4, 3'd3, 64'hFF80_0001, 64'h7FC0_0005, 1'b0, 4'h0);
        chk("R5 single default NaN", result, 64'h7FC0_0000);
        put_op(1'b1, 3'd1, 3'd3, 64'h0, 64'hFFF8_0000_0000_1234, 1'b0, 4'h0);
        chk("R5 double default NaN", result, 64'h7FF8_0000_0000_0000);
        chk("R5 hit under default mode", 64'(nan_hit), 64'h1);
        put_op(1'b1, 3'd1, 3'd2, 64'h1, 64'h2, 1'b0, 4'h0);
        chk("R3 no hit in default mode", 64'(nan_hit), 64'h0);
        chk("R3 zero result in default mode", result, 64'h0);
        idle();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule